// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It takes a clock derived from the oscillator and divides it by a programmable ratio. The result is the comparison clock for a phase detector. Each completed division produces a single-cycle pulse. In the prescaled mode, a divide-by-two stage feeds the programmable counter, so one output period lasts twice the set divisor. In the direct mode, the counter runs on every input cycle and the period equals the divisor.

The divisor and mode inputs are sampled on every cycle into a shadow stage. The running count picks up the shadow setting only on the cycle that ends a division, so a change never shortens or stretches the period already under way. Each mode has a legal range. An illegal divisor is replaced by the nearest legal value, and a range error flag is raised while the illegal value is presented. A reduced-range instance is made by lowering the maximum parameter, for example to 8191.

Top module: `fbdiv_top`

## Requirements
- R1: With modeSel = 1 (prescaled), the distance between successive output pulses is 2·N input-clock cycles for a legal divisor N.
- R2: With modeSel = 0 (direct), the distance between successive output pulses is N input-clock cycles for a legal divisor N, where the lowest legal direct divisor is 4.
- R3: pulseOut is high for exactly one input-clock cycle per division.
- R4: In prescaled mode, a divisor below 272 is treated as 272, and rangeErr is high in the cycle after that value is sampled.
- R5: In direct mode, a divisor below 4 is treated as 4, and rangeErr is high in the cycle after that value is sampled.
- R6: A divisor above the MAX_DIV parameter is treated as MAX_DIV, and rangeErr goes high. With MAX_DIV = 8191, an input of 9000 in prescaled mode gives a period of 16382.
- R7: A divisor or mode change made during a division leaves that division's length unchanged. The new setting governs the division that follows.
- R8: While reset is held and just after it is released, pulseOut and rangeErr are low. The first pulse comes 544 cycles after release (the reset setting is prescaled with divisor 272).
- R9: A legal divisor for the selected mode leaves rangeErr low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Oscillator-derived input clock |
| rstN | input | 1 | Active-low synchronous reset |
| divIn | input | 16 | Requested divisor N |
| modeSel | input | 1 | 1 = prescaled (ratio 2N), 0 = direct (ratio N) |
| pulseOut | output | 1 | One-cycle pulse per completed division |
| rangeErr | output | 1 | High while the sampled divisor lies outside the legal range |

## Verification
The main function is exercised with a set of divisors in both modes. The prescaled cases include 272 and 2014, and the direct cases include 145, 4 and 271. Comparing the two modes at the same divisor shows whether the divide-by-two stage is applied. Out-of-range values are also driven: 2 in direct mode and 100 and 271 in prescaled mode. The value 271 is legal in one mode and illegal in the other, which shows that the lower limit depends on the mode. Every change is made right after a pulse, and two intervals are measured after it. The first should keep the old length and the second should take the new length, which separates a boundary-only load from an immediate one. A reduced-range instance receives 9000, which checks the upper clamp.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  typedef enum logic {
    MODE_DIRECT   = 1'b0,
    MODE_PRESCALE = 1'b1
  } divMode_e;

  typedef struct packed {
    logic advance;
    logic load;
  } divStrobe_t;
endpackage

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MIN_PRE   = 272,
  parameter int MIN_DIR   = 4,
  parameter int MAX_DIV   = 65535,
  parameter int RESET_DIV = 272
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  logic             modeSel,
  input  logic             cntZero,
  output divStrobe_t       strb,
  output logic [DIV_W-1:0] loadVal,
  output logic             rangeErr
);
  localparam logic [DIV_W-1:0] MinPre   = DIV_W'(MIN_PRE);
  localparam logic [DIV_W-1:0] MinDir   = DIV_W'(MIN_DIR);
  localparam logic [DIV_W-1:0] MaxDiv   = DIV_W'(MAX_DIV);
  localparam logic [DIV_W-1:0] ResetDiv = DIV_W'(RESET_DIV);
  localparam bit FullTop = (MAX_DIV >= (2 ** DIV_W) - 1);

  logic [DIV_W-1:0] minSel, clampDiv, shadowDiv;
  logic             tooLow, tooHigh;
  divMode_e         shadowMode, actMode;
  logic             prePhase;

  assign minSel = modeSel ? MinPre : MinDir;
  assign tooLow = divIn < minSel;

  generate
    if (FullTop) begin : g_noHigh
      assign tooHigh = 1'b0;
    end else begin : g_high
      assign tooHigh = divIn > MaxDiv;
    end
  endgenerate

  always_comb begin
    clampDiv = divIn;
    if (tooLow)       clampDiv = minSel;
    else if (tooHigh) clampDiv = MaxDiv;
  end

  // shadow stage: sampled every cycle, consumed only at a boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowDiv  <= ResetDiv;
      shadowMode <= MODE_PRESCALE;
      rangeErr   <= 1'b0;
    end else begin
      shadowDiv  <= clampDiv;
      shadowMode <= divMode_e'(modeSel);
      rangeErr   <= tooLow | tooHigh;
    end
  end

  always_comb begin
    strb.advance = (actMode == MODE_PRESCALE) ? prePhase : 1'b1;
    strb.load    = strb.advance & cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMode  <= MODE_PRESCALE;
      prePhase <= 1'b0;
    end else begin
      if (strb.load) actMode <= shadowMode;
      if (strb.load || actMode == MODE_DIRECT) prePhase <= 1'b0;
      else prePhase <= ~prePhase;
    end
  end

  assign loadVal = shadowDiv - 1'b1;

  // R7: active mode only changes on a division boundary
  p_mode_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(actMode));
  // R1: the prescaled path advances at most every other cycle
  p_prescale_alt_r1: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_PRESCALE && strb.advance && !strb.load) |=> !strb.advance);
endmodule

// File: rtl/fbdiv_dp.sv
module fbdiv_dp
  import fbdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MAX_DIV   = 65535,
  parameter int RESET_DIV = 272
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strb,
  input  logic [DIV_W-1:0] loadVal,
  output logic             cntZero,
  output logic             pulseOut
);
  localparam logic [DIV_W-1:0] ResetCnt = DIV_W'(RESET_DIV - 1);
  localparam logic [DIV_W-1:0] TopCnt   = DIV_W'(MAX_DIV - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= ResetCnt;
      pulseOut <= 1'b0;
    end else begin
      if (strb.load)         cnt <= loadVal;
      else if (strb.advance) cnt <= cnt - 1'b1;
      pulseOut <= strb.load;
    end
  end

  assign cntZero = (cnt == '0);

  // R3: a pulse never lasts two cycles
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |=> !pulseOut);
  // R7: outside a boundary the count only steps down by one
  p_no_midload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.load) |=> cnt == $past(cnt) - 1'b1);
  // R6: the count never exceeds the largest legal divisor
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= TopCnt);
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MIN_PRE   = 272,
  parameter int MIN_DIR   = 4,
  parameter int MAX_DIV   = 65535,
  parameter int RESET_DIV = 272
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  logic             modeSel,
  output logic             pulseOut,
  output logic             rangeErr
);
  divStrobe_t       strb;
  logic [DIV_W-1:0] loadVal;
  logic             cntZero;

  fbdiv_ctrl #(
    .DIV_W(DIV_W), .MIN_PRE(MIN_PRE), .MIN_DIR(MIN_DIR),
    .MAX_DIV(MAX_DIV), .RESET_DIV(RESET_DIV)
  ) ctrl_i (
    .clk(clkIn), .rstN(rstN), .divIn(divIn), .modeSel(modeSel),
    .cntZero(cntZero), .strb(strb), .loadVal(loadVal), .rangeErr(rangeErr)
  );

  fbdiv_dp #(
    .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .RESET_DIV(RESET_DIV)
  ) dp_i (
    .clk(clkIn), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .cntZero(cntZero), .pulseOut(pulseOut)
  );
endmodule

// File: tb/fbdiv_top_tb_top.sv
module fbdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divIn = 16'd272;
  logic        modeSel = 1'b1;
  logic        pulseOut, rangeErr;
  logic [15:0] redDiv = 16'd9000;
  logic        redMode = 1'b1;
  logic        redPulse, redErr;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  fbdiv_top dut_i (
    .clkIn(clk), .rstN(rstN), .divIn(divIn), .modeSel(modeSel),
    .pulseOut(pulseOut), .rangeErr(rangeErr)
  );

  fbdiv_top #(.MAX_DIV(8191)) dutRed_i (
    .clkIn(clk), .rstN(rstN), .divIn(redDiv), .modeSel(redMode),
    .pulseOut(redPulse), .rangeErr(redErr)
  );

  localparam int VecN = 9;
  localparam logic        vMode [VecN] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0] vDiv  [VecN] = '{16'd272, 16'd2014, 16'd145, 16'd4, 16'd2, 16'd100, 16'd271, 16'd271, 16'd300};
  localparam int          vPer  [VecN] = '{544, 4028, 145, 4, 4, 544, 544, 271, 600};
  localparam logic        vErr  [VecN] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam string       vReq  [VecN] = '{"R1", "R1", "R2", "R2", "R5", "R4", "R4", "R2", "R1"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulseOut);
  endtask

  task automatic measureRed(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!redPulse);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int prevPer;
    repeat (3) @(negedge clk);
    check("R8 pulse in reset", int'(pulseOut), 0);
    check("R8 err in reset", int'(rangeErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 err after release", int'(rangeErr), 0);
    n = 1;
    while (!pulseOut) begin
      @(negedge clk);
      n++;
    end
    check("R8 first pulse", n, 544);
    prevPer = 544;

    // table walk: change right after a pulse, old length then new length
    for (int i = 0; i < VecN; i++) begin
      modeSel = vMode[i];
      divIn   = vDiv[i];
      measure(n);
      check("R7 old period kept", n, prevPer);
      measure(n);
      check(vReq[i], n, vPer[i]);
      check({vReq[i], " err flag"}, int'(rangeErr), int'(vErr[i]));
      prevPer = vPer[i];
    end

    // R3: pulse width one cycle
    @(negedge clk);
    check("R3 pulse width", int'(pulseOut), 0);
    measure(n);
    check("R3 remaining period", n, prevPer - 1);

    // R9: legal value clears the flag one cycle after sampling
    modeSel = 1'b0;
    divIn   = 16'd2;
    @(negedge clk);
    check("R5 flag raised", int'(rangeErr), 1);
    divIn = 16'd500;
    @(negedge clk);
    check("R9 flag cleared", int'(rangeErr), 0);

    // R6: reduced instance clamps 9000 to 8191
    while (!redPulse) @(negedge clk);
    measureRed(n);
    check("R6 reduced clamp period", n, 16382);
    check("R6 reduced err", int'(redErr), 1);
    redDiv = 16'd8191;
    @(negedge clk);
    check("R9 reduced max legal", int'(redErr), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule